// File: doc/BRIEF.md
# Three-Wire Serial Configuration Latch Loader

This block is a write-only configuration port for a dual-channel frequency synthesizer. Three inputs arrive from the outside: a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock moves one data bit into a 22-bit shift register, most significant bit first. When the load strobe rises, the two lowest bits of the shift register choose one of four configuration latches, and the upper 20 bits are copied into that latch.

Each channel has a reference latch and a counter latch. The reference latch holds the 14-bit reference divider value and six option bits. The counter latch holds the 6-bit A count, the 11-bit B count and two option bits. The latch contents leave the block as parallel fields that feed the divider and counter logic. A one-cycle update strobe marks the latch that was just written.

The three serial inputs are asynchronous to the system clock. They pass through synchronizer stages, and their edges are detected in the system clock domain.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is asserted, and after reset until the first load, every latch field and every update strobe bit is zero.
- R2: The shift register is 22 bits wide. A bit is captured only on a rising edge of `ser_clk`, and the first bit sent ends up in bit 21, so the word is sent most significant bit first.
- R3: Control code 00 (bits 1:0 of the word) loads the channel-2 reference latch: divider value = bits 15:2, options = bits 21:16.
- R4: Control code 01 loads the channel-2 counter latch: A = bits 7:2, B = bits 18:8, options = bits 20:19. Bit 21 has no effect.
- R5: Control code 10 loads the channel-1 reference latch, with the same field positions as R3.
- R6: Control code 11 loads the channel-1 counter latch, with the same field positions as R4.
- R7: A load changes only the latch that the control code selects. The other three latches keep their values.
- R8: Latch contents change only on a low-to-high transition of `ser_le`. Shifting while `ser_le` is low has no effect on the latches. Shifting while `ser_le` stays high also has no effect on them.
- R9: Each load pulses exactly one bit of `upd_stb` for exactly one system clock cycle. The bit index equals the control code.
- R10: When more than 22 bits are shifted before a load, only the last 22 bits count.
- R11: Changes on `ser_data` while `ser_clk` is steady have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe; its rising edge commits the word |
| ch1_r_div | output | 14 | Channel-1 reference divider value |
| ch1_r_opt | output | 6 | Channel-1 reference latch option bits |
| ch1_a_cnt | output | 6 | Channel-1 A count |
| ch1_b_cnt | output | 11 | Channel-1 B count |
| ch1_ab_opt | output | 2 | Channel-1 counter latch option bits |
| ch2_r_div | output | 14 | Channel-2 reference divider value |
| ch2_r_opt | output | 6 | Channel-2 reference latch option bits |
| ch2_a_cnt | output | 6 | Channel-2 A count |
| ch2_b_cnt | output | 11 | Channel-2 B count |
| ch2_ab_opt | output | 2 | Channel-2 counter latch option bits |
| upd_stb | output | 4 | One-cycle write strobe, one bit per latch, indexed by control code |

## Verification
Each of the four control codes is sent with distinct, asymmetric field values. This shows both the routing of a word to the correct latch and the bit position of every field; a byte swap or an off-by-one slice would produce a different value. Words sent with no load pulse, and words shifted while the load strobe stays high, separate edge-triggered commit from level-triggered commit. A word preceded by extra junk bits checks that earlier bits are discarded. A word whose data line toggles between clock edges checks that data is sampled only on the serial clock edge. The update strobe is counted cycle by cycle to confirm a single one-cycle pulse on the selected bit only.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WORD_W   = 22;
  localparam int CTRL_W   = 2;
  localparam int NUM_LAT  = 1 << CTRL_W;
  localparam int PAY_W    = WORD_W - CTRL_W;

  localparam int R_W      = 14;
  localparam int ROPT_W   = 6;
  localparam int A_W      = 6;
  localparam int B_W      = 11;
  localparam int ABOPT_W  = 2;

  // field offsets inside the payload (word bit minus CTRL_W)
  localparam int R_LSB     = 0;
  localparam int ROPT_LSB  = R_LSB + R_W;
  localparam int A_LSB     = 0;
  localparam int B_LSB     = A_LSB + A_W;
  localparam int ABOPT_LSB = B_LSB + B_W;

  typedef enum logic [CTRL_W-1:0] {
    SEL_CH2_REF = 2'b00,
    SEL_CH2_CNT = 2'b01,
    SEL_CH1_REF = 2'b10,
    SEL_CH1_CNT = 2'b11
  } latch_sel_e;

  typedef logic [PAY_W-1:0] payload_t;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_out,
  output logic rise_out
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_out = chain_q[STAGES-1];
  assign rise_out  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] word
);
  logic [WIDTH-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WIDTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_loader_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_en,
  input  logic [WORD_W-1:0]              word_in,
  output logic [NUM_LAT-1:0][PAY_W-1:0]  lat_q,
  output logic [NUM_LAT-1:0]             stb_q
);
  logic [CTRL_W-1:0]  sel;
  payload_t           payload;
  logic [NUM_LAT-1:0] wr_en;

  assign sel     = word_in[CTRL_W-1:0];
  assign payload = word_in[WORD_W-1:CTRL_W];

  generate
    for (genvar k = 0; k < NUM_LAT; k++) begin : g_lat
      payload_t lat_d;

      assign wr_en[k] = load_en && (sel == k[CTRL_W-1:0]);

      always_comb begin
        lat_d = lat_q[k];
        if (wr_en[k]) lat_d = payload;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q[k] <= '0;
        else        lat_q[k] <= lat_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= wr_en;
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  output logic [R_W-1:0]     ch1_r_div,
  output logic [ROPT_W-1:0]  ch1_r_opt,
  output logic [A_W-1:0]     ch1_a_cnt,
  output logic [B_W-1:0]     ch1_b_cnt,
  output logic [ABOPT_W-1:0] ch1_ab_opt,
  output logic [R_W-1:0]     ch2_r_div,
  output logic [ROPT_W-1:0]  ch2_r_opt,
  output logic [A_W-1:0]     ch2_a_cnt,
  output logic [B_W-1:0]     ch2_b_cnt,
  output logic [ABOPT_W-1:0] ch2_ab_opt,
  output logic [NUM_LAT-1:0] upd_stb
);
  localparam int CNT_USED = ABOPT_LSB + ABOPT_W;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic sclk_lvl, sclk_rise;
  logic sdat_lvl, sdat_rise_unused;
  logic le_lvl_unused, le_rise;

  cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_core_n), .async_in(ser_clk),
    .level_out(sclk_lvl), .rise_out(sclk_rise));
  cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_core_n), .async_in(ser_data),
    .level_out(sdat_lvl), .rise_out(sdat_rise_unused));
  cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_le (
    .clk(clk), .rst_n(rst_core_n), .async_in(ser_le),
    .level_out(le_lvl_unused), .rise_out(le_rise));

  logic [WORD_W-1:0] shift_word;

  cfg_shift_reg #(.WIDTH(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .shift_en(sclk_rise),
    .din(sdat_lvl), .word(shift_word));

  logic [NUM_LAT-1:0][PAY_W-1:0] lat_q;

  cfg_latch_bank u_bank (
    .clk(clk), .rst_n(rst_core_n), .load_en(le_rise),
    .word_in(shift_word), .lat_q(lat_q), .stb_q(upd_stb));

  payload_t c2r, c2c, c1r, c1c;
  assign c2r = lat_q[SEL_CH2_REF];
  assign c2c = lat_q[SEL_CH2_CNT];
  assign c1r = lat_q[SEL_CH1_REF];
  assign c1c = lat_q[SEL_CH1_CNT];

  assign ch2_r_div  = c2r[R_LSB +: R_W];
  assign ch2_r_opt  = c2r[ROPT_LSB +: ROPT_W];
  assign ch2_a_cnt  = c2c[A_LSB +: A_W];
  assign ch2_b_cnt  = c2c[B_LSB +: B_W];
  assign ch2_ab_opt = c2c[ABOPT_LSB +: ABOPT_W];

  assign ch1_r_div  = c1r[R_LSB +: R_W];
  assign ch1_r_opt  = c1r[ROPT_LSB +: ROPT_W];
  assign ch1_a_cnt  = c1c[A_LSB +: A_W];
  assign ch1_b_cnt  = c1c[B_LSB +: B_W];
  assign ch1_ab_opt = c1c[ABOPT_LSB +: ABOPT_W];

  logic unused_cnt_top;
  assign unused_cnt_top = ^{c2c[PAY_W-1:CNT_USED], c1c[PAY_W-1:CNT_USED], sclk_lvl};
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        le_rise,
  input logic [3:0]  upd_stb,
  input logic [19:0] ch2_ref,
  input logic [18:0] ch2_cnt,
  input logic [19:0] ch1_ref,
  input logic [18:0] ch1_cnt
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (upd_stb == 4'b0 && ch2_ref == '0 && ch1_ref == '0
                               && ch2_cnt == '0 && ch1_cnt == '0);
    end
  end

  // R9
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_stb));

  // R9
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb != 4'b0) |=> (upd_stb == 4'b0));

  // R8
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb != 4'b0) |-> $past(le_rise));

  // R7
  ch2_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[0] |-> $stable(ch2_ref));

  // R7
  ch2_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[1] |-> $stable(ch2_cnt));

  // R7
  ch1_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[2] |-> $stable(ch1_ref));

  // R7
  ch1_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[3] |-> $stable(ch1_cnt));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .le_rise(le_rise),
  .upd_stb(upd_stb),
  .ch2_ref({ch2_r_opt, ch2_r_div}),
  .ch2_cnt({ch2_ab_opt, ch2_b_cnt, ch2_a_cnt}),
  .ch1_ref({ch1_r_opt, ch1_r_div}),
  .ch1_cnt({ch1_ab_opt, ch1_b_cnt, ch1_a_cnt})
);

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
  logic clk, rst_n, ser_clk, ser_data, ser_le;
  logic [13:0] ch1_r_div, ch2_r_div;
  logic [5:0]  ch1_r_opt, ch2_r_opt, ch1_a_cnt, ch2_a_cnt;
  logic [10:0] ch1_b_cnt, ch2_b_cnt;
  logic [1:0]  ch1_ab_opt, ch2_ab_opt;
  logic [3:0]  upd_stb;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int stb_cnt [4];
  logic [21:0] exp_w [4];

  serial_cfg_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ch1_r_div(ch1_r_div), .ch1_r_opt(ch1_r_opt), .ch1_a_cnt(ch1_a_cnt),
    .ch1_b_cnt(ch1_b_cnt), .ch1_ab_opt(ch1_ab_opt),
    .ch2_r_div(ch2_r_div), .ch2_r_opt(ch2_r_opt), .ch2_a_cnt(ch2_a_cnt),
    .ch2_b_cnt(ch2_b_cnt), .ch2_ab_opt(ch2_ab_opt), .upd_stb(upd_stb));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) stb_cnt[k] += int'(upd_stb[k]);
  end

  task automatic step();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b, input bit noisy);
    ser_data = noisy ? ~b : b;
    step();
    ser_data = b;
    step();
    ser_clk = 1'b1;
    step();
    if (noisy) ser_data = ~b;
    step();
    ser_clk = 1'b0;
    step();
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n, input bit noisy);
    for (int i = n - 1; i >= 0; i--) ser_bit(v[i], noisy);
  endtask

  task automatic clear_stb();
    @(negedge clk);
    for (int k = 0; k < 4; k++) stb_cnt[k] = 0;
    #1;
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    step();
    ser_le = 1'b0;
    step();
    step();
  endtask

  task automatic chk_latches(input string req);
    @(negedge clk);
    chk(req, "ch2_r_div",  32'(ch2_r_div),  32'(exp_w[0][15:2]));
    chk(req, "ch2_r_opt",  32'(ch2_r_opt),  32'(exp_w[0][21:16]));
    chk(req, "ch2_a_cnt",  32'(ch2_a_cnt),  32'(exp_w[1][7:2]));
    chk(req, "ch2_b_cnt",  32'(ch2_b_cnt),  32'(exp_w[1][18:8]));
    chk(req, "ch2_ab_opt", 32'(ch2_ab_opt), 32'(exp_w[1][20:19]));
    chk(req, "ch1_r_div",  32'(ch1_r_div),  32'(exp_w[2][15:2]));
    chk(req, "ch1_r_opt",  32'(ch1_r_opt),  32'(exp_w[2][21:16]));
    chk(req, "ch1_a_cnt",  32'(ch1_a_cnt),  32'(exp_w[3][7:2]));
    chk(req, "ch1_b_cnt",  32'(ch1_b_cnt),  32'(exp_w[3][18:8]));
    chk(req, "ch1_ab_opt", 32'(ch1_ab_opt), 32'(exp_w[3][20:19]));
    #1;
  endtask

  task automatic chk_stb(input string req, input int code);
    for (int k = 0; k < 4; k++)
      chk(req, $sformatf("upd_stb[%0d] high cycles", k), 32'(stb_cnt[k]),
          (k == code) ? 32'd1 : 32'd0);
  endtask

  task automatic load_word(input logic [21:0] w, input string req, input bit noisy);
    shift_bits(32'(w), 22, noisy);
    clear_stb();
    pulse_le();
    exp_w[w[1:0]] = w;
    chk_latches(req);
    chk_stb("R9", int'(w[1:0]));
  endtask

  // R1
  task automatic t_reset();
    for (int k = 0; k < 4; k++) exp_w[k] = '0;
    chk_latches("R1");
    chk("R1", "upd_stb", 32'(upd_stb), 32'd0);
  endtask

  // R2 R3
  task automatic t_ch2_ref();
    load_word({6'h2D, 14'h1A5B, 2'b00}, "R3", 1'b0);
    chk("R2", "ch2 divider msb-first", 32'(ch2_r_div), 32'h1A5B);
  endtask

  // R4 R7
  task automatic t_ch2_cnt();
    load_word({1'b1, 2'b10, 11'h5C3, 6'h2B, 2'b01}, "R4", 1'b0);
    chk("R4", "ch2 cnt bit21 ignored", 32'(ch2_ab_opt), 32'h2);
    chk("R7", "ch2 ref kept", 32'(ch2_r_div), 32'h1A5B);
  endtask

  // R5
  task automatic t_ch1_ref();
    load_word({6'h13, 14'h2C71, 2'b10}, "R5", 1'b0);
  endtask

  // R6
  task automatic t_ch1_cnt();
    load_word({1'b0, 2'b01, 11'h2A6, 6'h35, 2'b11}, "R6", 1'b0);
  endtask

  // R8: shifting with load strobe low
  task automatic t_no_le();
    clear_stb();
    shift_bits(32'({6'h3F, 14'h0F0F, 2'b00}), 22, 1'b0);
    step();
    chk_latches("R8");
    chk("R8", "no strobe without load", 32'(stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3]), 32'd0);
  endtask

  // R8: shifting with load strobe held high
  task automatic t_le_held();
    logic [21:0] w1;
    w1 = {6'h05, 14'h0123, 2'b00};
    shift_bits(32'(w1), 22, 1'b0);
    clear_stb();
    ser_le = 1'b1;
    step();
    step();
    exp_w[0] = w1;
    shift_bits(32'({6'h3A, 14'h3210, 2'b10}), 22, 1'b0);
    chk_latches("R8");
    chk_stb("R8", 0);
    ser_le = 1'b0;
    step();
    step();
    chk_latches("R8");
  endtask

  // R10
  task automatic t_overflow();
    shift_bits(32'hA5, 8, 1'b0);
    load_word({2'b11, 11'h4D2, 6'h0E, 1'b1, 2'b01}, "R10", 1'b0);
  endtask

  // R11
  task automatic t_noisy_data();
    load_word({6'h2A, 14'h155A, 2'b10}, "R11", 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    ser_clk = 1'b0;
    ser_data = 1'b0;
    ser_le = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_ch2_ref();
    t_ch2_cnt();
    t_ch1_ref();
    t_ch1_cnt();
    t_no_le();
    t_le_held();
    t_overflow();
    t_noisy_data();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule